// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at the shared state of a set of interrupt lines and, for each of several processor targets, picks the one interrupt that target should be offered next. Every cycle it examines one interrupt ID. It decides whether that interrupt is eligible and which target it is steered to. It then compares the interrupt against the best candidate held so far for that target. The result for each target is the winning interrupt ID, its priority and its group. When no interrupt qualifies, the target shows an idle indication.

The scan runs without pause over IDs 32 up to `NUM_IRQ-1`, which takes `NUM_IRQ-32` cycles. In the last cycle of each pass, the per-target results are copied to registered outputs and a one-cycle `scan_done_o` strobe is raised. Between strobes the outputs keep their last value. A pass that starts after an input change reflects that change, so the second strobe after a change always carries the new answer.

Each interrupt has a 64-bit routing word that steers it. If bit 31 of the word is set, the interrupt goes to the lowest-indexed present target that accepts distributed interrupts of its group. Otherwise it goes to the lowest-indexed present target whose affinity matches the word in all four fields.

Top module: `irq_hp_select`

## Requirements
- R1: An interrupt is a candidate only when it is pending, enabled and not active, and the enable bit for its group is set. Group codes are 0 = group 0, 1 = non-secure group 1 and 2 = secure group 1, and the code selects bit `grp_en_i[code]`. Group code 3 is never a candidate.
- R2: Among a target's candidates, the numerically lowest priority value wins.
- R3: When candidates of a target have equal priority, the lower interrupt ID wins.
- R4: A priority of all ones is never a candidate. A target with no candidate shows all-ones priority, ID 0, group 0 and `out_idle_o` set to 1.
- R5: When routing word bit 31 is set, the interrupt goes to the lowest-indexed target that has `tgt_present_i` set and has `tgt_accept_i[t*3+code]` set for the interrupt's group code.
- R6: When routing word bit 31 is clear, the interrupt goes to the lowest-indexed present target for which all four fields match. Routing bits 39:32, 23:16, 15:8 and 7:0 are compared with bits 31:24, 23:16, 15:8 and 7:0 of that target's `tgt_aff_i` word.
- R7: An interrupt that reaches no present target shows up at no target.
- R8: Only IDs 32 to `NUM_IRQ-1` are scanned. Lower IDs never appear at any output, and the highest ID does take part.
- R9: `scan_done_o` pulses for one cycle every `NUM_IRQ-32` cycles. The outputs change only in a pulse cycle. The result shown at the second pulse after an input change reflects the new inputs.
- R10: During reset and until the first pulse, every target is idle and `scan_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | NUM_IRQ | Pending flag per interrupt |
| en_i | input | NUM_IRQ | Enable flag per interrupt |
| act_i | input | NUM_IRQ | Active flag per interrupt |
| prio_i | input | NUM_IRQ*PRIO_W | Priority per interrupt, ID i at bits i*PRIO_W |
| grp_i | input | NUM_IRQ*2 | Resolved group code per interrupt |
| grp_en_i | input | 3 | Enable per group code |
| route_i | input | NUM_IRQ*64 | Routing word per interrupt |
| tgt_aff_i | input | NUM_TGT*32 | Affinity ID per target |
| tgt_present_i | input | NUM_TGT | Target present flags |
| tgt_accept_i | input | NUM_TGT*3 | Per target, accepts distributed interrupts of each group code |
| out_id_o | output | NUM_TGT*ID_W | Selected interrupt ID per target |
| out_prio_o | output | NUM_TGT*PRIO_W | Selected priority per target |
| out_grp_o | output | NUM_TGT*2 | Selected group code per target |
| out_idle_o | output | NUM_TGT | Target has no candidate |
| scan_done_o | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The bench aims at the following corner cases, and at how a faulty design would fail each one:
- Equal priorities arriving in both ID orders. A comparison that used less-or-equal would hand the target the later, higher ID.
- An eligible interrupt with all-ones priority. A design that failed to reject it would report it instead of idle.
- Interrupts at ID 31 and at the last ID. An off-by-one scan range would either leak ID 31 or drop the top line.
- An affinity word that differs only in the top field, and a distributed interrupt whose first accepting target is absent. A design that missed the top field or ignored presence would deliver these to the wrong target.
- Reading the outputs between strobes right after an input change. A design that let the outputs follow the scan would show partial results there.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
   // resolved group codes; code 3 is reserved and never eligible
   typedef enum logic [1:0] {
      GRP_G0    = 2'd0,
      GRP_G1NS  = 2'd1,
      GRP_G1S   = 2'd2,
      GRP_RSVD  = 2'd3
   } grp_e;

   localparam int ROUTE_W     = 64;
   localparam int AFF_W       = 32;
   localparam int NGRP        = 3;
   localparam int SCAN_FIRST  = 32;
   localparam int ONE_OF_N_BIT = 31;
endpackage

// File: rtl/irq_scan_ctr.sv
module irq_scan_ctr #(
   parameter int FIRST = 32,
   parameter int LAST  = 63,
   parameter int W     = 6
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] idx_o,
   output logic         last_o
);
   localparam logic [W-1:0] FIRST_V = W'(FIRST);
   localparam logic [W-1:0] LAST_V  = W'(LAST);

   assign last_o = (idx_o == LAST_V);

   always_ff @(posedge clk) begin
      if (rst)         idx_o <= FIRST_V;
      else if (last_o) idx_o <= FIRST_V;
      else             idx_o <= idx_o + 1'b1;
   end

   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      (idx_o >= FIRST_V) && (idx_o <= LAST_V));
endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
   import irq_sel_pkg::*;
#(
   parameter int NUM_TGT = 4
) (
   input  logic [ROUTE_W-1:0]       route_i,
   input  logic [1:0]               grp_i,
   input  logic [NUM_TGT*AFF_W-1:0] tgt_aff_i,
   input  logic [NUM_TGT-1:0]       tgt_present_i,
   input  logic [NUM_TGT*NGRP-1:0]  tgt_accept_i,
   output logic [NUM_TGT-1:0]       hit_o
);
   logic               spread;
   logic [NUM_TGT-1:0] match;
   logic [23:0]        route_unused;

   assign spread       = route_i[ONE_OF_N_BIT];
   assign route_unused = {route_i[63:40], route_i[30:24], 1'b0};

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      logic [AFF_W-1:0] aff;
      logic [3:0]       acc4;
      logic             aff_eq;
      assign aff    = tgt_aff_i[t*AFF_W +: AFF_W];
      assign acc4   = {1'b0, tgt_accept_i[t*NGRP +: NGRP]};
      assign aff_eq = (route_i[39:32] == aff[31:24]) &&
                      (route_i[23:16] == aff[23:16]) &&
                      (route_i[15:8]  == aff[15:8])  &&
                      (route_i[7:0]   == aff[7:0]);
      assign match[t] = tgt_present_i[t] & (spread ? acc4[grp_i] : aff_eq);
   end

   // lowest index wins in both modes
   always_comb begin
      logic found;
      found = 1'b0;
      hit_o = '0;
      for (int t = 0; t < NUM_TGT; t++) begin
         if (match[t] && !found) begin
            hit_o[t] = 1'b1;
            found    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_best_slot.sv
module irq_best_slot #(
   parameter int PRIO_W = 8,
   parameter int ID_W   = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              last_i,
   input  logic              cand_vld_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic [1:0]        cand_grp_i,
   output logic [PRIO_W-1:0] res_prio_o,
   output logic [ID_W-1:0]   res_id_o,
   output logic [1:0]        res_grp_o,
   output logic              res_idle_o
);
   localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

   logic [PRIO_W-1:0] best_prio, nxt_prio;
   logic [ID_W-1:0]   best_id, nxt_id;
   logic [1:0]        best_grp, nxt_grp;
   logic              win;

   // strict compare: the all-ones idle value can never be beaten by itself,
   // and an equal later (higher) ID never displaces the held one
   assign win      = cand_vld_i && (cand_prio_i < best_prio);
   assign nxt_prio = win ? cand_prio_i : best_prio;
   assign nxt_id   = win ? cand_id_i   : best_id;
   assign nxt_grp  = win ? cand_grp_i  : best_grp;

   always_ff @(posedge clk) begin
      if (rst) begin
         best_prio  <= IDLE_PRIO;
         best_id    <= '0;
         best_grp   <= '0;
         res_prio_o <= IDLE_PRIO;
         res_id_o   <= '0;
         res_grp_o  <= '0;
         res_idle_o <= 1'b1;
      end else if (last_i) begin
         res_prio_o <= nxt_prio;
         res_id_o   <= nxt_id;
         res_grp_o  <= nxt_grp;
         res_idle_o <= (nxt_prio == IDLE_PRIO);
         best_prio  <= IDLE_PRIO;
         best_id    <= '0;
         best_grp   <= '0;
      end else begin
         best_prio  <= nxt_prio;
         best_id    <= nxt_id;
         best_grp   <= nxt_grp;
      end
   end

   // R2
   best_monotone_chk: assert property (@(posedge clk) disable iff (rst)
      !last_i |=> (best_prio <= $past(best_prio)));

   // R9
   res_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !last_i |=> ($stable(res_prio_o) && $stable(res_id_o) && $stable(res_idle_o)));

   // R1
   res_grp_chk: assert property (@(posedge clk) disable iff (rst)
      !res_idle_o |-> (res_grp_o != 2'd3));
endmodule

// File: rtl/irq_hp_select.sv
module irq_hp_select
   import irq_sel_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_TGT = 4,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = $clog2(NUM_IRQ)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_IRQ-1:0]         pend_i,
   input  logic [NUM_IRQ-1:0]         en_i,
   input  logic [NUM_IRQ-1:0]         act_i,
   input  logic [NUM_IRQ*PRIO_W-1:0]  prio_i,
   input  logic [NUM_IRQ*2-1:0]       grp_i,
   input  logic [NGRP-1:0]            grp_en_i,
   input  logic [NUM_IRQ*ROUTE_W-1:0] route_i,
   input  logic [NUM_TGT*AFF_W-1:0]   tgt_aff_i,
   input  logic [NUM_TGT-1:0]         tgt_present_i,
   input  logic [NUM_TGT*NGRP-1:0]    tgt_accept_i,
   output logic [NUM_TGT*ID_W-1:0]    out_id_o,
   output logic [NUM_TGT*PRIO_W-1:0]  out_prio_o,
   output logic [NUM_TGT*2-1:0]       out_grp_o,
   output logic [NUM_TGT-1:0]         out_idle_o,
   output logic                       scan_done_o
);
   localparam int LAST_ID  = NUM_IRQ - 1;
   localparam int SCAN_LEN = NUM_IRQ - SCAN_FIRST;

   if (NUM_IRQ <= SCAN_FIRST || NUM_IRQ > 1020) begin : g_bad_irq
      $error("NUM_IRQ must be in 33..1020");
   end
   if (NUM_TGT < 1) begin : g_bad_tgt
      $error("NUM_TGT must be at least 1");
   end
   if (ID_W < $clog2(NUM_IRQ) || PRIO_W < 2) begin : g_bad_w
      $error("ID_W or PRIO_W too narrow");
   end

   logic [ID_W-1:0]    idx;
   logic               last;
   logic [PRIO_W-1:0]  c_prio;
   logic [1:0]         c_grp;
   logic [ROUTE_W-1:0] c_route;
   logic [3:0]         grp_en_x;
   logic               c_elig;
   logic [NUM_TGT-1:0] hit;

   irq_scan_ctr #(.FIRST(SCAN_FIRST), .LAST(LAST_ID), .W(ID_W)) u_ctr (
      .clk(clk), .rst(rst), .idx_o(idx), .last_o(last)
   );

   assign c_prio   = prio_i[idx*PRIO_W +: PRIO_W];
   assign c_grp    = grp_i[idx*2 +: 2];
   assign c_route  = route_i[idx*ROUTE_W +: ROUTE_W];
   assign grp_en_x = {1'b0, grp_en_i};
   assign c_elig   = pend_i[idx] & en_i[idx] & ~act_i[idx] & grp_en_x[c_grp];

   irq_route_sel #(.NUM_TGT(NUM_TGT)) u_route (
      .route_i(c_route), .grp_i(c_grp), .tgt_aff_i(tgt_aff_i),
      .tgt_present_i(tgt_present_i), .tgt_accept_i(tgt_accept_i), .hit_o(hit)
   );

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
      irq_best_slot #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_slot (
         .clk(clk), .rst(rst), .last_i(last),
         .cand_vld_i(c_elig & hit[t]),
         .cand_prio_i(c_prio), .cand_id_i(idx), .cand_grp_i(c_grp),
         .res_prio_o(out_prio_o[t*PRIO_W +: PRIO_W]),
         .res_id_o(out_id_o[t*ID_W +: ID_W]),
         .res_grp_o(out_grp_o[t*2 +: 2]),
         .res_idle_o(out_idle_o[t])
      );

      // R8
      out_id_range_chk: assert property (@(posedge clk) disable iff (rst)
         !out_idle_o[t] |-> (out_id_o[t*ID_W +: ID_W] >= ID_W'(SCAN_FIRST)));

      // R5
      spread_accept_chk: assert property (@(posedge clk) disable iff (rst)
         (hit[t] && c_route[ONE_OF_N_BIT]) |->
            (tgt_present_i[t] && (c_grp != 2'd3) && tgt_accept_i[t*NGRP + c_grp]));
   end

   always_ff @(posedge clk) begin
      if (rst) scan_done_o <= 1'b0;
      else     scan_done_o <= last;
   end

   // R7
   route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));

   if (SCAN_LEN > 1) begin : g_pulse_chk
      // R9
      scan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
         scan_done_o |=> !scan_done_o);
   end
endmodule

// File: tb/irq_hp_select_bench.sv
module irq_hp_select_bench;
   localparam int N    = 64;
   localparam int T    = 4;
   localparam int PW   = 8;
   localparam int IW   = 6;
   localparam int SCAN = N - 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [N-1:0]    pend, en, act;
   logic [N*PW-1:0] prio;
   logic [N*2-1:0]  grp;
   logic [2:0]      grp_en;
   logic [N*64-1:0] route;
   logic [T*32-1:0] taff;
   logic [T-1:0]    tpres;
   logic [T*3-1:0]  tacc;
   logic [T*IW-1:0] o_id;
   logic [T*PW-1:0] o_prio;
   logic [T*2-1:0]  o_grp;
   logic [T-1:0]    o_idle;
   logic            done;

   int n_tests = 0;
   int n_fail  = 0;

   irq_hp_select #(.NUM_IRQ(N), .NUM_TGT(T), .PRIO_W(PW)) u_irq_hp_select (
      .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .act_i(act),
      .prio_i(prio), .grp_i(grp), .grp_en_i(grp_en), .route_i(route),
      .tgt_aff_i(taff), .tgt_present_i(tpres), .tgt_accept_i(tacc),
      .out_id_o(o_id), .out_prio_o(o_prio), .out_grp_o(o_grp),
      .out_idle_o(o_idle), .scan_done_o(done)
   );

   function automatic logic [63:0] aff_word(input logic [7:0] a3, input logic [7:0] a0);
      return {24'h0, a3, 1'b0, 7'h0, 8'h02, 8'h01, a0};
   endfunction

   function automatic logic [63:0] spread_word();
      return 64'h0000_0000_8000_0000;
   endfunction

   function automatic int ref_tgt(input int id);
      logic [63:0] w = route[id*64 +: 64];
      int g = int'(grp[id*2 +: 2]);
      for (int t = 0; t < T; t++) begin
         if (!tpres[t]) continue;
         if (w[31]) begin
            if (g < 3 && tacc[t*3 + g]) return t;
         end else if (w[39:32] == taff[t*32+24 +: 8] && w[23:16] == taff[t*32+16 +: 8] &&
                      w[15:8] == taff[t*32+8 +: 8] && w[7:0] == taff[t*32 +: 8]) begin
            return t;
         end
      end
      return -1;
   endfunction

   task automatic check(input string req, input int t);
      int bp = 255, bid = 0, bg = 0;
      for (int id = 32; id < N; id++) begin
         int g = int'(grp[id*2 +: 2]);
         int p = int'(prio[id*PW +: PW]);
         if (!(pend[id] && en[id] && !act[id] && g < 3 && grp_en[g])) continue;
         if (ref_tgt(id) != t) continue;
         if (p < bp) begin bp = p; bid = id; bg = g; end
      end
      n_tests++;
      if (o_prio[t*PW +: PW] != bp[7:0] || o_id[t*IW +: IW] != bid[5:0] ||
          o_grp[t*2 +: 2] != bg[1:0] || o_idle[t] != (bp == 255)) begin
         n_fail++;
         $display("FAIL %s tgt%0d: got id=%0d prio=%h grp=%0d idle=%b exp id=%0d prio=%h grp=%0d idle=%b",
                  req, t, o_id[t*IW +: IW], o_prio[t*PW +: PW], o_grp[t*2 +: 2], o_idle[t],
                  bid, bp, bg, (bp == 255));
      end
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic settle_check(input string req);
      wait_done();
      wait_done();
      for (int t = 0; t < T; t++) check(req, t);
   endtask

   task automatic clear_all();
      pend = '0; en = '0; act = '0; prio = '1; grp = '0; grp_en = 3'b111;
      for (int i = 0; i < N; i++) route[i*64 +: 64] = aff_word(8'd7, 8'd7);
   endtask

   task automatic put(input int id, input logic [7:0] p, input logic [1:0] g, input logic [63:0] w);
      pend[id] = 1'b1; en[id] = 1'b1; act[id] = 1'b0;
      prio[id*PW +: PW] = p; grp[id*2 +: 2] = g; route[id*64 +: 64] = w;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int t = 0; t < T; t++) taff[t*32 +: 32] = {8'(t), 8'h02, 8'h01, 8'(t)};
      tpres = '1; tacc = '1;
      clear_all();
      put(40, 8'h10, 2'd1, aff_word(8'd0, 8'd0));
      repeat (3) @(negedge clk);
      // R10: reset state
      for (int t = 0; t < T; t++) begin
         n_tests++;
         if (!o_idle[t] || o_prio[t*PW +: PW] != 8'hFF || done) begin
            n_fail++;
            $display("FAIL R10 reset tgt%0d: got idle=%b prio=%h done=%b exp 1 ff 0",
                     t, o_idle[t], o_prio[t*PW +: PW], done);
         end
      end
      rst = 1'b0;
      for (int k = 0; k < SCAN - 1; k++) begin
         @(negedge clk);
         n_tests++;
         if (done || !o_idle[0]) begin
            n_fail++;
            $display("FAIL R10 before first pulse: got done=%b idle=%b exp 0 1", done, o_idle[0]);
         end
      end
      // R9: pulse spacing
      wait_done();
      begin
         int gap = 0;
         do begin @(negedge clk); gap++; end while (!done);
         n_tests++;
         if (gap != SCAN) begin
            n_fail++;
            $display("FAIL R9 pulse spacing: got %0d exp %0d", gap, SCAN);
         end
      end
      // R1 basic
      for (int t = 0; t < T; t++) check("R1", t);
      act[40] = 1'b1;           settle_check("R1 active");
      act[40] = 1'b0; grp_en = 3'b101; settle_check("R1 group off");
      grp_en = 3'b111; grp[40*2 +: 2] = 2'd3; settle_check("R1 group3");
      grp[40*2 +: 2] = 2'd1; en[40] = 1'b0; settle_check("R1 disabled");
      // R9 hold between pulses
      en[40] = 1'b1; settle_check("R9 setup");
      wait_done();
      pend[40] = 1'b0;
      for (int k = 0; k < SCAN - 1; k++) begin
         @(negedge clk);
         n_tests++;
         if (o_idle[0] || o_id[0 +: IW] != 6'd40) begin
            n_fail++;
            $display("FAIL R9 hold: got idle=%b id=%0d exp 0 40", o_idle[0], o_id[0 +: IW]);
         end
      end
      settle_check("R9 update");
      // R2, R3
      clear_all();
      put(50, 8'h20, 2'd0, aff_word(8'd2, 8'd2));
      put(60, 8'h10, 2'd0, aff_word(8'd2, 8'd2));
      settle_check("R2");
      clear_all();
      put(45, 8'h20, 2'd1, aff_word(8'd1, 8'd1));
      put(33, 8'h20, 2'd1, aff_word(8'd1, 8'd1));
      put(34, 8'h20, 2'd2, aff_word(8'd3, 8'd3));
      put(59, 8'h20, 2'd2, aff_word(8'd3, 8'd3));
      settle_check("R3");
      // R4
      clear_all();
      put(41, 8'hFF, 2'd0, aff_word(8'd0, 8'd0));
      settle_check("R4");
      // R5
      clear_all();
      tacc = 12'b111_111_101_000;
      put(42, 8'h30, 2'd1, spread_word());
      put(43, 8'h30, 2'd0, spread_word());
      settle_check("R5");
      tpres = 4'b1101;
      settle_check("R5 absent");
      tpres = '1; tacc = '1;
      // R6, R7
      clear_all();
      put(44, 8'h05, 2'd0, aff_word(8'd9, 8'd1));
      put(47, 8'h06, 2'd0, aff_word(8'd3, 8'd3));
      settle_check("R7 R6");
      tpres = 4'b0111;
      settle_check("R7 absent");
      tpres = '1;
      // R8
      clear_all();
      put(31, 8'h00, 2'd0, aff_word(8'd0, 8'd0));
      put(5, 8'h00, 2'd0, aff_word(8'd1, 8'd1));
      put(63, 8'h40, 2'd0, aff_word(8'd1, 8'd1));
      settle_check("R8");
      // random
      for (int r = 0; r < 40; r++) begin
         for (int i = 0; i < N; i++) begin
            int sel = int'($urandom_range(0, 9));
            pend[i] = ($urandom_range(0, 9) < 7);
            en[i]   = ($urandom_range(0, 9) < 8);
            act[i]  = ($urandom_range(0, 9) < 1);
            grp[i*2 +: 2] = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
               0: prio[i*PW +: PW] = 8'h10;
               1: prio[i*PW +: PW] = 8'h20;
               2: prio[i*PW +: PW] = 8'hFF;
               default: prio[i*PW +: PW] = 8'($urandom_range(0, 255));
            endcase
            if (sel < 5)      route[i*64 +: 64] = aff_word(8'(sel % 4), 8'(sel % 4));
            else if (sel < 7) route[i*64 +: 64] = aff_word(8'(sel), 8'd0);
            else              route[i*64 +: 64] = spread_word();
         end
         grp_en = 3'($urandom_range(0, 7));
         tpres  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
         tacc   = 12'($urandom_range(0, 4095));
         settle_check("R1 R2 R3 R5 R6 random");
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule